// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative TLB

This block is a translation lookaside buffer in which every entry is compared against the incoming virtual address at the same time. There is no indexed set. Each entry stores its own page-size code, and that code decides how many upper address bits take part in the entry's compare. A large page therefore occupies a single entry instead of many small ones. A lookup is purely combinational. It yields a hit flag, the index of the winning entry, the translated physical address, and a flag that shows when more than one entry matched.

Entries are loaded through a write port in one clock edge. The target slot is either an explicit index or a round-robin victim pointer that steps through the array. A synchronous flush invalidates the whole array and rewinds the pointer. Page-table walks, permissions and address-space tags are left to the surrounding logic.

Top module: `varpage_tlb`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and the victim pointer is 0.
- R2: A valid entry hits when the virtual-address bits at and above its page boundary equal the corresponding stored virtual tag bits. Address bits below the boundary take no part in the compare.
- R3: The 2-bit size code selects the page boundary at bit 12 + 4*code: code 0 is 4 KiB, code 1 is 64 KiB, code 2 is 1 MiB and code 3 is 16 MiB. The stored tags hold address bits 31..12.
- R4: On a hit, the physical address takes the stored physical tag bits above the winning entry's boundary and the virtual-address bits below it. On a miss, the physical address is 0.
- R5: An entry written with its valid bit clear never hits, whatever its stored tag and size.
- R6: When several valid entries match, the lowest index is reported and its translation is used, and the multi-hit flag is 1. The multi-hit flag is 0 when at most one entry matches.
- R7: A lookup is combinational. A write takes effect at the rising edge and is first seen by a lookup in the following cycle.
- R8: A write without an explicit index goes to the victim pointer's slot, and the pointer then advances by one, wrapping from entry 15 to entry 0.
- R9: A write with an explicit index goes to that slot and leaves the victim pointer unchanged.
- R10: A flush clears every valid bit and sets the victim pointer to 0 at the next edge. A write requested in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkVaddr | input | 32 | Virtual address to translate |
| lkHit | output | 1 | Some valid entry matches |
| lkMulti | output | 1 | More than one valid entry matches |
| lkIdx | output | 4 | Index of the lowest matching entry |
| lkPaddr | output | 32 | Translated physical address, 0 on miss |
| wrReq | input | 1 | Load one entry at this edge |
| wrExplicit | input | 1 | Use wrIndex instead of the victim pointer |
| wrIndex | input | 4 | Explicit target slot |
| wrVtag | input | 20 | Virtual tag, address bits 31..12 |
| wrSize | input | 2 | Page-size code |
| wrPtag | input | 20 | Physical tag, address bits 31..12 |
| wrEntryValid | input | 1 | Valid bit stored with the entry |
| flushReq | input | 1 | Invalidate all entries, rewind the pointer |
| victimIdx | output | 4 | Current round-robin victim slot |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 16 entries. With these values the pointer wrap from 15 to 0 is reached after sixteen pointer writes. All four size codes are exercised, down to the 16 MiB case in which only the top eight tag bits are compared. The tags are drawn from a narrow pool, so entries of different sizes overlap often. This brings the lowest-index priority and the multi-hit flag within reach of random traffic as well as of the directed cases.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_BASE = 12;
  localparam int SIZE_STEP = 4;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic wrEn;
    logic flush;
  } tlb_strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             wrExplicit,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic             flushReq,
  output tlb_strobe_t      strobe,
  output logic [IDX_W-1:0] wrSlot,
  output logic [IDX_W-1:0] victimIdx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] victimQ;
  logic             useVictim;

  assign useVictim    = wrReq && !wrExplicit && !flushReq;
  assign strobe.flush = flushReq;
  assign strobe.wrEn  = wrReq && !flushReq;
  assign wrSlot       = wrExplicit ? wrIndex : victimQ;
  assign victimIdx    = victimQ;

  always_ff @(posedge clk) begin
    if (!rstN) victimQ <= '0;
    else if (flushReq) victimQ <= '0;
    else if (useVictim) victimQ <= (victimQ == LAST) ? '0 : victimQ + 1'b1;
  end

  p_victim_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrExplicit && !flushReq) |=>
      victimIdx == (($past(victimIdx) == LAST) ? '0 : $past(victimIdx) + 1'b1));

  p_victim_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!flushReq && !(wrReq && !wrExplicit)) |=> $stable(victimIdx));

  p_flush_rewind_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> victimIdx == '0);
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_W = $clog2(ENTRIES),
  parameter int TAG_W = ADDR_W - PAGE_BASE
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlb_strobe_t       strobe,
  input  logic [IDX_W-1:0]  wrSlot,
  input  logic [TAG_W-1:0]  wrVtag,
  input  logic [1:0]        wrSize,
  input  logic [TAG_W-1:0]  wrPtag,
  input  logic              wrEntryValid,
  input  logic [ADDR_W-1:0] lkVaddr,
  output logic              lkHit,
  output logic              lkMulti,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPaddr
);
  logic [ENTRIES-1:0] validQ;
  logic [1:0]         sizeQ [ENTRIES];
  logic [TAG_W-1:0]   vtagQ [ENTRIES];
  logic [TAG_W-1:0]   ptagQ [ENTRIES];
  logic [ENTRIES-1:0] hitVec;
  logic [TAG_W-1:0]   vaTag;

  function automatic logic [TAG_W-1:0] keepMask(input logic [1:0] sz);
    return {TAG_W{1'b1}} << (SIZE_STEP * int'(sz));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else if (strobe.flush) validQ <= '0;
    else if (strobe.wrEn) validQ[wrSlot] <= wrEntryValid;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      sizeQ[wrSlot] <= wrSize;
      vtagQ[wrSlot] <= wrVtag;
      ptagQ[wrSlot] <= wrPtag;
    end
  end

  assign vaTag = lkVaddr[ADDR_W-1:PAGE_BASE];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_match
    assign hitVec[e] = validQ[e] &&
      (((vtagQ[e] ^ vaTag) & keepMask(sizeQ[e])) == '0);
  end

  always_comb begin
    lkIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) lkIdx = IDX_W'(i);
    end
  end

  logic [1:0]        selSize;
  logic [ADDR_W-1:0] offMask;
  logic [ADDR_W-1:0] selBase;

  assign lkHit   = |hitVec;
  assign lkMulti = $countones(hitVec) > 1;
  assign selSize = sizeQ[lkIdx];
  assign offMask = ~({ADDR_W{1'b1}} << (PAGE_BASE + SIZE_STEP * int'(selSize)));
  assign selBase = {ptagQ[lkIdx], {PAGE_BASE{1'b0}}};
  assign lkPaddr = lkHit ? ((selBase & ~offMask) | (lkVaddr & offMask)) : '0;

  p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    lkMulti |-> lkHit);

  p_idx_is_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> validQ[lkIdx]);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !lkHit);

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && wrEntryValid) |=> validQ[$past(wrSlot)]);
endmodule

// File: rtl/varpage_tlb.sv
module varpage_tlb
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int TAG_W = ADDR_W - PAGE_BASE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkVaddr,
  output logic              lkHit,
  output logic              lkMulti,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPaddr,
  input  logic              wrReq,
  input  logic              wrExplicit,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [TAG_W-1:0]  wrVtag,
  input  logic [1:0]        wrSize,
  input  logic [TAG_W-1:0]  wrPtag,
  input  logic              wrEntryValid,
  input  logic              flushReq,
  output logic [IDX_W-1:0]  victimIdx
);
  tlb_strobe_t      strobe;
  logic [IDX_W-1:0] wrSlot;

  tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrExplicit(wrExplicit),
    .wrIndex(wrIndex), .flushReq(flushReq), .strobe(strobe),
    .wrSlot(wrSlot), .victimIdx(victimIdx)
  );

  tlb_array #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot),
    .wrVtag(wrVtag), .wrSize(wrSize), .wrPtag(wrPtag),
    .wrEntryValid(wrEntryValid), .lkVaddr(lkVaddr), .lkHit(lkHit),
    .lkMulti(lkMulti), .lkIdx(lkIdx), .lkPaddr(lkPaddr)
  );
endmodule

// File: tb/sim_varpage_tlb.sv
`timescale 1ns/1ps
module sim_varpage_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkHit, lkMulti;
  logic [3:0]  lkIdx;
  logic [31:0] lkPaddr;
  logic        wrReq = 1'b0, wrExplicit = 1'b0, wrEntryValid = 1'b0, flushReq = 1'b0;
  logic [3:0]  wrIndex = '0;
  logic [19:0] wrVtag = '0, wrPtag = '0;
  logic [1:0]  wrSize = '0;
  logic [3:0]  victimIdx;

  always #4 clk = ~clk;

  varpage_tlb u0 (
    .clk(clk), .rstN(rstN), .lkVaddr(lkVaddr), .lkHit(lkHit), .lkMulti(lkMulti),
    .lkIdx(lkIdx), .lkPaddr(lkPaddr), .wrReq(wrReq), .wrExplicit(wrExplicit),
    .wrIndex(wrIndex), .wrVtag(wrVtag), .wrSize(wrSize), .wrPtag(wrPtag),
    .wrEntryValid(wrEntryValid), .flushReq(flushReq), .victimIdx(victimIdx)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  bit          mValid [16];
  int          mSize  [16];
  logic [19:0] mVtag  [16];
  logic [19:0] mPtag  [16];
  int          mVictim = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] va, bit we, bit ex, int idx,
                      logic [19:0] vt, int sz, logic [19:0] pt, bit val, bit fl);
    int first, cnt, off, slot;
    logic [31:0] lo, expPa;
    lkVaddr = va; wrReq = we; wrExplicit = ex; wrIndex = 4'(idx);
    wrVtag = vt; wrSize = 2'(sz); wrPtag = pt; wrEntryValid = val; flushReq = fl;
    #1;
    first = -1; cnt = 0;
    for (int i = 0; i < 16; i++) begin
      if (mValid[i] && (((mVtag[i] ^ va[31:12]) >> (4 * mSize[i])) == 0)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    expPa = '0;
    if (first >= 0) begin
      off = 12 + 4 * mSize[first];
      lo = (32'd1 << off) - 1;
      expPa = ({mPtag[first], 12'h000} & ~lo) | (va & lo);
    end
    vectors++;
    check(tag, "hit(R2)", 32'(lkHit), 32'(first >= 0));
    check(tag, "multi(R6)", 32'(lkMulti), 32'(cnt > 1));
    if (first >= 0) check(tag, "index(R6)", 32'(lkIdx), 32'(first));
    check(tag, "paddr(R4)", lkPaddr, expPa);
    check(tag, "victim(R8)", 32'(victimIdx), 32'(mVictim));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < 16; i++) mValid[i] = 0;
      mVictim = 0;
    end else if (we) begin
      slot = ex ? idx : mVictim;
      mValid[slot] = val; mSize[slot] = sz; mVtag[slot] = vt; mPtag[slot] = pt;
      if (!ex) mVictim = (mVictim + 1) % 16;
    end
    @(negedge clk);
  endtask

  task automatic look(string tag, logic [31:0] va);
    step(tag, va, 0, 0, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mSize[i] = 0; mVtag[i] = '0; mPtag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    look("R1", 32'h0000_0000);
    look("R1", 32'hFFFF_F123);
    // R7: write and lookup in the same cycle misses, next cycle hits
    step("R7", 32'h1234_5678, 1, 1, 0, 20'h12345, 0, 20'hABCDE, 1, 0);
    look("R7", 32'h1234_5678);
    // R2/R3: each size code, varied low bits
    step("R3", 32'h0, 1, 1, 1, 20'h56780, 1, 20'h11110, 1, 0);
    step("R3", 32'h0, 1, 1, 2, 20'h9AB00, 2, 20'h22200, 1, 0);
    step("R3", 32'h0, 1, 1, 3, 20'hC5000, 3, 20'h33000, 1, 0);
    look("R3", 32'h5678_FFFF);
    look("R3", 32'h5679_0000);
    look("R3", 32'h9AB4_2424);
    look("R3", 32'h9AC0_0000);
    look("R3", 32'hC5FE_DCBA);
    look("R3", 32'hC400_0001);
    look("R2", 32'h1234_5FFF);
    look("R2", 32'h1234_6000);
    // R5: invalid entry with a matching tag
    step("R5", 32'h0, 1, 1, 4, 20'h77777, 0, 20'h44444, 0, 0);
    look("R5", 32'h7777_7000);
    // R6: overlapping entries, lower index wins
    step("R6", 32'h0, 1, 1, 6, 20'hC5123, 0, 20'h55555, 1, 0);
    look("R6", 32'hC512_3456);
    step("R6", 32'h0, 1, 1, 5, 20'hC5120, 1, 20'h66660, 1, 0);
    look("R6", 32'hC512_3456);
    look("R6", 32'hC512_7000);
    // R8: victim writes wrap past entry 15
    for (int k = 0; k < 17; k++)
      step("R8", 32'h0, 1, 0, 0, 20'(32'h40000 + k), 0, 20'(32'h80000 + k), 1, 0);
    look("R8", 32'h4000_F111);
    look("R8", 32'h4001_0222);
    // R9: explicit writes leave the pointer alone
    step("R9", 32'h0, 1, 1, 9, 20'hDEAD0, 1, 20'hBEEF0, 1, 0);
    step("R9", 32'hDEAD_1234, 1, 1, 15, 20'h00001, 0, 20'h00002, 1, 0);
    look("R9", 32'hDEAD_1234);
    // R10: flush, then flush with a competing write
    step("R10", 32'h0, 1, 0, 0, 20'h40003, 0, 20'h1, 1, 1);
    look("R10", 32'h4000_3000);
    step("R10", 32'h0, 1, 1, 2, 20'h9AB00, 2, 20'h1, 1, 0);
    step("R10", 32'h9AB0_0000, 1, 0, 0, 20'h9AB00, 3, 20'h2, 1, 1);
    look("R10", 32'h9AB0_0000);
    // mixed traffic over a narrow tag pool
    for (int k = 0; k < 600; k++) begin
      logic [19:0] vt, vq;
      int r;
      r = int'($urandom_range(0, 99));
      vt = 20'hC3000 | (20'($urandom) & 20'h03303);
      vq = 20'hC3000 | (20'($urandom) & 20'h03303);
      step("R6", {vq, 12'($urandom)}, r < 35, r < 15, int'($urandom_range(0, 15)),
           vt, int'($urandom_range(0, 3)), 20'($urandom), r != 3, r == 99);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule